// File: doc/BRIEF.md
# Two-Pin Fault Signal Encoder

This block turns a single "system is faulty" indication into a pattern on two output pins. An external checker can read the pattern and tell a live, healthy system from a faulted one. It can also tell both apart from a dead or stuck one. Three encodings can be selected:

- **Paired toggling (dual-rail):** both pins toggle. They are in antiphase when healthy and in phase when faulted.
- **Time switching:** the pins keep toggling while healthy and freeze at fixed levels on a fault.
- **Bi-stable:** the pins hold static levels that swap on a fault.

A prescaled toggle source sets the rate for the toggling encodings. It toggles once every `FIX_DIV × (N+1)` input clock cycles, so one full pin period spans `FIX_DIV × (N+1) × 2` cycles. `FIX_DIV` is 4096 by default and `N` is a 6-bit input. The configuration logic that feeds this block supplies N = 7 out of reset.

Each pin has its own polarity inversion, applied as the last stage. A test-mode code can blank both pins. The fault indication comes from a separate state machine and is an input here.

Internally there are four parts. A prescaler counter produces a one-cycle `tick`. A two-state phase machine (states `PH_LOW` and `PH_HIGH`) moves `PH_LOW → PH_HIGH` on a tick and `PH_HIGH → PH_LOW` on a tick, and holds its state otherwise. An encoder maps mode, fault and phase to raw pin levels. A polarity stage inverts each pin when its polarity bit is set.

Top module: `flt_sig_out`

## Requirements
- R1: While `rst_n` is low, the prescaler counter is zero and the phase is `PH_LOW`. After release with mode 00, no fault, polarity 00 and test code 00, `sig_out0`=0 and `sig_out1`=1.
- R2: The phase flips once every `FIX_DIV × (presc_val+1)` rising clock edges counted from reset release. After k such edges the phase is `(k / L) mod 2` with L = `FIX_DIV × (presc_val+1)`, as long as `presc_val` is held constant.
- R3: With mode 00 and no fault, raw pin0 equals the phase and raw pin1 is its inverse.
- R4: With mode 00 and a fault, raw pin0 and raw pin1 both equal the phase.
- R5: With mode 01 and no fault, raw pin0 equals the phase and raw pin1 is its inverse.
- R6: With mode 01 and a fault, raw pin0 is 0 and raw pin1 is 1, whatever the phase.
- R7: With mode 10, raw pin0=1 and raw pin1=0 when there is no fault, and raw pin0=0 and raw pin1=1 when there is a fault.
- R8: Mode code 11 behaves exactly like mode 00.
- R9: Each output pin is its raw value XOR its polarity bit: `pol_sel[0]` inverts `sig_out0` and `pol_sel[1]` inverts `sig_out1`.
- R10: Test code 01 forces both raw pins to 0 before polarity is applied. Codes 00, 10 and 11 leave the pins active.
- R11: The mode, fault, polarity and test inputs act on the pins in the same cycle. Changing them does not disturb the phase sequence of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_active | input | 1 | High while the system is in Fault state |
| mode_sel | input | 2 | Encoding: 00 paired toggling, 01 time switching, 10 bi-stable, 11 treated as 00 |
| pol_sel | input | 2 | Bit 0 inverts pin 0, bit 1 inverts pin 1 |
| presc_val | input | 6 | Prescaler value N |
| test_sel | input | 2 | 01 blanks the pins; any other code leaves them active |
| sig_out0 | output | 1 | Fault output pin 0 |
| sig_out1 | output | 1 | Fault output pin 1 |

## Verification
The phase assertions assume the prescaler value does not change while the counter runs. A change mid-count would let the counter exceed the new limit for one cycle. The bench therefore changes `presc_val` only while reset is held. The pin assertions sample combinational outputs at the rising edge, so they assume mode, fault, polarity and test inputs settle between edges. The bench drives all inputs at the falling edge to meet this.

// File: rtl/flt_sig_pkg.sv
package flt_sig_pkg;

    typedef enum logic [1:0] {
        ENC_DUAL = 2'b00,
        ENC_TSW  = 2'b01,
        ENC_BIST = 2'b10,
        ENC_RSVD = 2'b11
    } enc_mode_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    localparam logic [1:0] TST_BLANK_CODE = 2'b01;

endpackage

// File: rtl/flt_sig_prescaler.sv
module flt_sig_prescaler #(
    parameter int FIX_DIV = 4096,
    parameter int PRE_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] presc,
    output logic             tick
);
    localparam int CNT_W = $clog2(FIX_DIV * (2 ** PRE_W));
    localparam int LW    = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [LW-1:0]    lim;
    logic [LW-1:0]    cnt_inc;

    assign lim     = LW'(FIX_DIV) * (LW'(presc) + LW'(1));
    assign cnt_inc = {1'b0, cnt_q} + LW'(1);
    assign tick    = (cnt_inc >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim > LW'(1)) |=> !tick) else $error("tick repeated");  // R2

    AST_RESET_CNT: assert property (@(posedge clk)
        !rst_n |-> cnt_q == '0) else $error("counter not cleared");  // R1

endmodule

// File: rtl/flt_sig_phase.sv
module flt_sig_phase
    import flt_sig_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    output phase_e phase
);
    phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (tick) state_d = PH_HIGH;
            PH_HIGH: if (tick) state_d = PH_LOW;
        endcase
    end

    assign phase = state_q;

    AST_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> state_q != $past(state_q)) else $error("phase did not flip");  // R2

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_q)) else $error("phase moved without tick");  // R2

    AST_PHASE_RESET: assert property (@(posedge clk)
        !rst_n |-> state_q == PH_LOW) else $error("phase not reset");  // R1

endmodule

// File: rtl/flt_sig_encoder.sv
module flt_sig_encoder
    import flt_sig_pkg::*;
(
    input  enc_mode_e  mode,
    input  logic       fault,
    input  phase_e     phase,
    input  logic       blank,
    output logic [1:0] raw
);
    logic ph;
    assign ph = (phase == PH_HIGH);

    always_comb begin
        raw = 2'b00;
        if (!blank) begin
            unique case (mode)
                ENC_TSW: begin
                    if (fault) raw = 2'b10;
                    else       raw = {~ph, ph};
                end
                ENC_BIST: begin
                    if (fault) raw = 2'b10;
                    else       raw = 2'b01;
                end
                ENC_DUAL, ENC_RSVD: begin
                    if (fault) raw = {ph, ph};
                    else       raw = {~ph, ph};
                end
            endcase
        end
    end

endmodule

// File: rtl/flt_sig_out.sv
module flt_sig_out
    import flt_sig_pkg::*;
#(
    parameter int FIX_DIV = 4096,
    parameter int PRE_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_active,
    input  logic [1:0]       mode_sel,
    input  logic [1:0]       pol_sel,
    input  logic [PRE_W-1:0] presc_val,
    input  logic [1:0]       test_sel,
    output logic             sig_out0,
    output logic             sig_out1
);
    localparam int NPIN = 2;

    logic       tick;
    phase_e     phase;
    logic       blank;
    logic [1:0] raw;
    logic [NPIN-1:0] pins;

    assign blank = (test_sel == TST_BLANK_CODE);

    flt_sig_prescaler #(.FIX_DIV(FIX_DIV), .PRE_W(PRE_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .presc (presc_val),
        .tick  (tick)
    );

    flt_sig_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .phase (phase)
    );

    flt_sig_encoder u_enc (
        .mode  (enc_mode_e'(mode_sel)),
        .fault (fault_active),
        .phase (phase),
        .blank (blank),
        .raw   (raw)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pol
        assign pins[g] = raw[g] ^ pol_sel[g];
    end

    assign sig_out0 = pins[0];
    assign sig_out1 = pins[1];

    AST_BLANK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (test_sel == 2'b01) |-> ({sig_out1, sig_out0} == pol_sel)) else $error("blank");  // R10

    AST_BIST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b10 && test_sel != 2'b01) |->
        ((sig_out0 ^ pol_sel[0]) == !fault_active && (sig_out1 ^ pol_sel[1]) == fault_active))
        else $error("bistable");  // R7

    AST_DUAL_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'b01 && mode_sel != 2'b10 && !fault_active && test_sel != 2'b01) |->
        ((sig_out0 ^ pol_sel[0]) != (sig_out1 ^ pol_sel[1]))) else $error("dual split");  // R3

    AST_TSW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b01 && fault_active && test_sel != 2'b01) |->
        (!(sig_out0 ^ pol_sel[0]) && (sig_out1 ^ pol_sel[1]))) else $error("tsw fault");  // R6

endmodule

// File: tb/test_flt_sig_out.sv
module test_flt_sig_out;

    localparam int FIX = 4;

    typedef struct {
        string      req;
        logic [1:0] exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fault_active = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [1:0] pol_sel = 2'b00;
    logic [5:0] presc_val = 6'd0;
    logic [1:0] test_sel = 2'b00;
    logic       sig_out0, sig_out1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    flt_sig_out #(.FIX_DIV(FIX), .PRE_W(6)) i_flt_sig_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_active (fault_active),
        .mode_sel     (mode_sel),
        .pol_sel      (pol_sel),
        .presc_val    (presc_val),
        .test_sel     (test_sel),
        .sig_out0     (sig_out0),
        .sig_out1     (sig_out1)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic logic [1:0] model(input int k, input int n, input logic [1:0] m,
                                         input logic f, input logic [1:0] p, input logic [1:0] t);
        logic ph;
        logic [1:0] r;
        ph = ((k / (FIX * (n + 1))) % 2) == 1;
        case (m)
            2'b01:   r = f ? 2'b10 : {~ph, ph};
            2'b10:   r = f ? 2'b10 : 2'b01;
            default: r = f ? {ph, ph} : {~ph, ph};
        endcase
        if (t == 2'b01) r = 2'b00;
        return r ^ p;
    endfunction

    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        presc_val = 6'(n);
        mode_sel = 2'b00; fault_active = 1'b0; pol_sel = 2'b00; test_sel = 2'b00;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        sb_q.push_back('{req: "R1", exp: 2'b10});
    endtask

    task automatic step(input string req, input logic [1:0] m, input logic f,
                        input logic [1:0] p, input logic [1:0] t);
        @(negedge clk);
        mode_sel = m; fault_active = f; pol_sel = p; test_sel = t;
        #1;
        sb_q.push_back('{req: req, exp: model(cyc, int'(presc_val), m, f, p, t)});
    endtask

    always @(negedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if ({sig_out1, sig_out0} !== it.exp) begin
                errors++;
                $display("FAIL %s: pins {1,0}=%b expected %b at cycle %0d",
                         it.req, {sig_out1, sig_out0}, it.exp, cyc);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(0);
        for (int i = 0; i < 12; i++) step("R3", 2'b00, 1'b0, 2'b00, 2'b00);
        for (int i = 0; i < 10; i++) step("R4", 2'b00, 1'b1, 2'b00, 2'b00);
        for (int i = 0; i < 10; i++) step("R5", 2'b01, 1'b0, 2'b00, 2'b00);
        for (int i = 0; i < 10; i++) step("R6", 2'b01, 1'b1, 2'b00, 2'b00);
        for (int i = 0; i < 6; i++)  step("R7", 2'b10, 1'b0, 2'b00, 2'b00);
        for (int i = 0; i < 6; i++)  step("R7", 2'b10, 1'b1, 2'b00, 2'b00);
        for (int i = 0; i < 10; i++) step("R8", 2'b11, 1'b0, 2'b00, 2'b00);
        for (int i = 0; i < 10; i++) step("R8", 2'b11, 1'b1, 2'b00, 2'b00);
        for (int p = 1; p < 4; p++) begin
            for (int i = 0; i < 6; i++) step("R9", 2'b00, 1'b0, 2'(p), 2'b00);
            step("R9", 2'b10, 1'b1, 2'(p), 2'b00);
            step("R9", 2'b01, 1'b1, 2'(p), 2'b00);
        end
        for (int p = 0; p < 4; p++) begin
            step("R10", 2'b00, 1'b0, 2'(p), 2'b01);
            step("R10", 2'b10, 1'b0, 2'(p), 2'b01);
            step("R10", 2'b01, 1'b1, 2'(p), 2'b01);
        end
        for (int i = 0; i < 6; i++) step("R10", 2'b00, 1'b1, 2'b00, 2'b10);
        for (int i = 0; i < 6; i++) step("R10", 2'b01, 1'b0, 2'b00, 2'b11);
        for (int i = 0; i < 16; i++)
            step("R11", 2'(i % 4), 1'(i % 3 == 0), 2'(i % 2), 2'(i % 5 == 4 ? 1 : 0));
        do_reset(2);
        for (int i = 0; i < 40; i++) step("R2", 2'b00, 1'b0, 2'b00, 2'b00);
        do_reset(7);
        for (int i = 0; i < 70; i++) step("R2", 2'b01, 1'b0, 2'b01, 2'b00);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule